// File: doc/BRIEF.md
# Seven-Level Interrupt Priority Encoder

This block takes seven active-low interrupt request lines, captures them in a register on the processor clock, and presents the highest pending level to a processor as a 3-bit active-low priority code. Request line `req_n[i]` carries level `i+1`. Level 7 is the most urgent, and there is no level 0 request: code 0 means "nothing pending". Several sources may pull the same line low together, because levels 1 to 6 are sensed by level and not by edge.

The block also models the processor's side of the exchange. It compares the encoded level with the processor's current 3-bit mask and raises `accept` in any cycle where that request would be taken. While `accept` is high, it drives the mask the processor would adopt. Levels 1 to 6 are taken only when they are strictly above the mask. Level 7 ignores the mask. It is taken once, in the cycle where the encoded level first becomes 7 after being below 7. Acknowledgement is autovectored, so the block supplies no vector. While the boot-hold input is high, every request is suppressed.

The request, mask and boot-hold inputs are plain control pins with no data stream. For that reason the block has no valid/ready handshake and no back-pressure.

Top module: `intr_level_encoder`

## Requirements
- R1: After reset, `ipl_n` reads 3'b111, `accept` is 0 and `new_mask` equals `cur_mask`.
- R2: A change on `req_n` shows on `ipl_n` only after the next rising clock edge, and never in the same cycle.
- R3: `ipl_n` is the bitwise inverse of the highest level whose line was low at the last edge. Bit i of `req_n` is level i+1. When several lines are low, the highest level wins.
- R4: With no request line low, `ipl_n` is 3'b111 and `accept` is 0.
- R5: While `boot_hold` is 1, `ipl_n` is 3'b111 and `accept` is 0, whatever the request lines carry.
- R6: An encoded level from 1 to 6 raises `accept` only when it is strictly greater than `cur_mask`. A level equal to or below the mask is not taken.
- R7: When `accept` is 1, `new_mask` equals the accepted level. Otherwise `new_mask` equals `cur_mask`.
- R8: Level 7 raises `accept` in the first cycle in which the encoded level is 7 after a cycle in which it was below 7. This holds for every mask value, including 7.
- R9: While the encoded level stays at 7, `accept` stays 0 after that first cycle, whatever the mask. A fresh accept needs the level to fall below 7 and return.
- R10: A level from 1 to 6 that stays above `cur_mask` raises `accept` in every cycle it is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | 7 | Active-low request lines; bit i is level i+1 |
| boot_hold | input | 1 | High while booting; suppresses all requests |
| cur_mask | input | 3 | Processor's current interrupt mask |
| ipl_n | output | 3 | Active-low encoded highest pending level |
| accept | output | 1 | High when the pending level would be taken |
| new_mask | output | 3 | Mask after acceptance (or `cur_mask` if none) |

## Verification
The bench targets the equal-to-mask boundary. A design using greater-or-equal would take a level 3 request against mask 3. It holds level 7 for many cycles under masks 7 and 3. A design treating level 7 like the other levels would either refuse it at mask 7 or re-accept it every cycle, and one that never re-arms would miss the second rise after a dip to level 5. It releases `boot_hold` while level 7 is held. A design that keeps its edge history through boot would then miss the accept. It also drives a change on `req_n` and checks that cycle. An unregistered path would show the new level one cycle early.

// File: rtl/ile_pkg.sv
package ile_pkg;
  localparam int unsigned LEVELS = 7;
  localparam int unsigned LVL_W  = $clog2(LEVELS + 1);
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/ile_req_sync.sv
// Capture stage for the active-low request lines; output is active-high.
module ile_req_sync #(
  parameter int N      = 7,
  parameter int STAGES = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_n,
  output logic [N-1:0] req_q
);
  logic [N-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= ~req_n;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign req_q = stg[STAGES-1];
endmodule

// File: rtl/ile_prio_enc.sv
// Highest-set-bit encoder with a suppress input; code 0 means idle.
module ile_prio_enc #(
  parameter int N  = 7,
  parameter int LW = $clog2(N + 1)
) (
  input  logic [N-1:0]  req_q,
  input  logic          inhibit,
  output logic [LW-1:0] lvl
);
  always_comb begin
    lvl = '0;
    for (int i = 0; i < N; i++) begin
      if (req_q[i]) lvl = LW'(i + 1);
    end
    if (inhibit) lvl = '0;
  end
endmodule

// File: rtl/ile_accept.sv
// Acceptance decision: strict compare for lower levels, edge for the top level.
module ile_accept #(
  parameter int N  = 7,
  parameter int LW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] lvl,
  input  logic [LW-1:0] cur_mask,
  output logic          accept,
  output logic [LW-1:0] new_mask
);
  localparam logic [LW-1:0] TOP = LW'(N);

  logic [LW-1:0] prev_lvl;
  logic          top_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_lvl <= '0;
    else        prev_lvl <= lvl;
  end

  assign top_rise = (lvl == TOP) && (prev_lvl != TOP);

  always_comb begin
    accept = 1'b0;
    if (lvl == TOP)      accept = top_rise;
    else if (lvl != '0)  accept = (lvl > cur_mask);
    new_mask = accept ? lvl : cur_mask;
  end
endmodule

// File: rtl/intr_level_encoder.sv
module intr_level_encoder #(
  parameter  int NUM_LVL     = ile_pkg::LEVELS,
  parameter  int SYNC_STAGES = 1,
  localparam int LW          = $clog2(NUM_LVL + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LVL-1:0] req_n,
  input  logic               boot_hold,
  input  logic [LW-1:0]      cur_mask,
  output logic [LW-1:0]      ipl_n,
  output logic               accept,
  output logic [LW-1:0]      new_mask
);
  logic [NUM_LVL-1:0] req_q;
  logic [LW-1:0]      lvl;

  ile_req_sync #(.N(NUM_LVL), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .req_n (req_n),
    .req_q (req_q)
  );

  ile_prio_enc #(.N(NUM_LVL), .LW(LW)) u_enc (
    .req_q   (req_q),
    .inhibit (boot_hold),
    .lvl     (lvl)
  );

  ile_accept #(.N(NUM_LVL), .LW(LW)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl      (lvl),
    .cur_mask (cur_mask),
    .accept   (accept),
    .new_mask (new_mask)
  );

  assign ipl_n = ~lvl;
endmodule

// File: rtl/ile_checker.sv
module ile_checker #(
  parameter  int NUM_LVL = 7,
  localparam int LW      = $clog2(NUM_LVL + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          boot_hold,
  input logic [LW-1:0] cur_mask,
  input logic [LW-1:0] ipl_n,
  input logic          accept,
  input logic [LW-1:0] new_mask
);
  localparam logic [LW-1:0] TOP = LW'(NUM_LVL);

  logic [LW-1:0] seen;
  logic [LW-1:0] seen_prev;

  assign seen = ~ipl_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_prev <= '0;
    else        seen_prev <= seen;
  end

  a_r5_boot_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    boot_hold |-> (ipl_n == '1 && !accept));

  a_r4_idle_no_take: assert property (@(posedge clk) disable iff (!rst_n)
    (seen == '0) |-> !accept);

  a_r6_strict_above: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && seen != TOP) |-> (seen > cur_mask));

  a_r7_mask_taken: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (new_mask == seen));

  a_r7_mask_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |-> (new_mask == cur_mask));

  a_r8_top_rise_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (seen == TOP && seen_prev != TOP) |-> accept);

  a_r9_top_held_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (seen == TOP && seen_prev == TOP) |-> !accept);
endmodule

bind intr_level_encoder ile_checker #(.NUM_LVL(NUM_LVL)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .boot_hold (boot_hold),
  .cur_mask  (cur_mask),
  .ipl_n     (ipl_n),
  .accept    (accept),
  .new_mask  (new_mask)
);

// File: tb/intr_level_encoder_bench.sv
module intr_level_encoder_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] req_n = 7'h7f;
  logic       boot_hold = 1'b0;
  logic [2:0] cur_mask = 3'd0;
  logic [2:0] ipl_n;
  logic       accept;
  logic [2:0] new_mask;

  int total = 0;
  int bad = 0;

  // behavioural reference state
  logic [6:0] m_pend = '0;
  int         m_prev = 0;

  always #5 clk = ~clk;

  intr_level_encoder u_intr_level_encoder (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .boot_hold(boot_hold),
    .cur_mask(cur_mask), .ipl_n(ipl_n), .accept(accept), .new_mask(new_mask)
  );

  function automatic int top_level(input logic [6:0] p);
    for (int i = 6; i >= 0; i--) if (p[i]) return i + 1;
    return 0;
  endfunction

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // Drive one cycle of inputs, check outputs before the edge, then advance the model.
  task automatic step(input logic [6:0] rq_n, input logic bt, input logic [2:0] mk,
                      input string tag);
    int  lv;
    bit  acc;
    int  nm;
    @(negedge clk);
    req_n = rq_n; boot_hold = bt; cur_mask = mk;
    #1;
    lv  = bt ? 0 : top_level(m_pend);
    if (lv == 7)      acc = (m_prev != 7);
    else if (lv != 0) acc = (lv > int'(mk));
    else              acc = 0;
    nm = acc ? lv : int'(mk);
    total++;
    if (ipl_n !== 3'(~lv) || accept !== acc || new_mask !== 3'(nm)) begin
      bad++;
      $display("FAIL %s: ipl_n=%b accept=%b new_mask=%0d expected ipl_n=%b accept=%b new_mask=%0d",
               tag, ipl_n, accept, new_mask, 3'(~lv), acc, nm);
    end
    @(posedge clk);
    m_pend = ~rq_n;
    m_prev = lv;
  endtask

  localparam logic [6:0] NONE = 7'h7f;
  function automatic logic [6:0] lv_n(input int l);
    logic [6:0] r = NONE;
    if (l > 0) r[l-1] = 1'b0;
    return r;
  endfunction

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    finish_run();
  end

  initial begin
    int seed = 32'h1234_5678;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    step(NONE, 0, 3'd0, "R1 reset idle");
    step(NONE, 0, 3'd4, "R1 reset mask passthrough");

    // R2: new request not visible in the same cycle
    step(lv_n(3), 0, 3'd0, "R2 not same cycle");
    step(lv_n(3), 0, 3'd0, "R2 R6 R7 level 3 taken");
    step(lv_n(3), 0, 3'd0, "R10 held level 3 retaken");
    step(lv_n(3), 0, 3'd3, "R6 equal to mask refused");
    step(lv_n(3), 0, 3'd5, "R6 below mask refused");
    step(lv_n(3), 0, 3'd2, "R10 R6 above mask again");

    // R3: several lines
    step(lv_n(2) & lv_n(5), 0, 3'd0, "R3 prep");
    step(lv_n(2) & lv_n(5), 0, 3'd1, "R3 two lines highest wins");
    step(lv_n(1) & lv_n(4) & lv_n(6), 0, 3'd6, "R3 prep three");
    step(lv_n(1) & lv_n(4) & lv_n(6), 0, 3'd6, "R3 R6 six at mask six");
    step(NONE, 0, 3'd0, "R4 release");
    step(NONE, 0, 3'd0, "R4 idle after release");

    // R8/R9: top level against mask 7
    step(lv_n(7), 0, 3'd7, "R8 prep");
    step(lv_n(7), 0, 3'd7, "R8 top taken at mask 7");
    step(lv_n(7), 0, 3'd7, "R9 top held");
    step(lv_n(7), 0, 3'd3, "R9 top held low mask");
    step(lv_n(5), 0, 3'd7, "R9 dip prep");
    step(lv_n(5), 0, 3'd7, "R6 level 5 under mask 7");
    step(lv_n(7), 0, 3'd7, "R8 rerise prep");
    step(lv_n(7), 0, 3'd7, "R8 top retaken after dip");
    step(lv_n(7), 0, 3'd0, "R9 held mask 0");

    // R5: boot hold
    step(lv_n(7) & lv_n(4), 1, 3'd0, "R5 boot hides");
    step(lv_n(7) & lv_n(4), 1, 3'd0, "R5 boot still hides");
    step(lv_n(7) & lv_n(4), 0, 3'd0, "R5 R8 boot release top taken");
    step(lv_n(4), 1, 3'd0, "R5 boot mid run");
    step(NONE, 0, 3'd0, "R4 final idle");

    // mixed sequence
    for (int k = 0; k < 600; k++) begin
      logic [6:0] rq;
      logic       bt;
      logic [2:0] mk;
      seed = seed * 1103515245 + 12345;
      rq = 7'(seed >>> 9) | 7'(seed >>> 17);
      mk = 3'(seed >>> 3);
      bt = ((seed >>> 24) & 15) == 0;
      step(rq, bt, mk, "R6 R8 R9 R10 mixed");
    end

    finish_run();
  end
endmodule